// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an external asynchronous static RAM of 1024 words by 4 bits. The RAM has an active-low select, an active-low write strobe and a shared data bus. The host issues one word access at a time over a valid/ready handshake. The controller turns each access into a strobe sequence whose every interval meets the RAM's timing limits. A read returns its data with a single-cycle valid pulse.

All RAM timing limits are parameters in nanoseconds. So is the clock period. Each limit becomes a cycle count equal to the ceiling of the ratio, and never less than one cycle. Where several limits bear on one phase of a cycle, that phase lasts as long as the largest of them needs. The data bus leaves the block as a value, a drive enable and a returned value, so the three-state buffer can sit in the pad ring.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is held, and right after it is released, `mem_cs_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `req_ready` is 1.
- R2: Every interval is ceil(ns / CLK_NS) cycles, with a minimum of 1. With the defaults and a 4 ns clock this gives 3 cycles for address setup, 7 for the select lead, 13 for the strobe width and for bus release, 9 for data setup, 2 for data hold and for recovery, 34 for the cycle and access times, 20 for address-to-end and 22 for select-to-end.
- R3: A read drives `mem_cs_n` low and keeps `mem_we_n` high. The returned value is sampled on the clock edge that falls N_AA cycles after select fell. That value appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, one cycle after the sampling edge.
- R4: On a write, `mem_we_n` falls max(N_AS, N_CSL) cycles after `mem_cs_n` falls. `mem_we_n` is low only while `mem_cs_n` is low. `mem_addr` never changes while select is low.
- R5: `mem_we_n` stays low for max(N_WP, N_WZ+N_DS, N_AW−setup, N_CW−setup) cycles. That is 22 with the defaults.
- R6: `mem_dq_oe` rises N_WZ cycles after `mem_we_n` falls and falls N_DH cycles after `mem_we_n` rises. While `mem_dq_oe` is high, `mem_dq_o` carries the accepted write data.
- R7: `mem_cs_n` and `mem_we_n` rise on the same edge, ending the write. The address is then held for the rest of the cycle.
- R8: `req_ready` falls on the edge that accepts a request, together with select. It rises again when the full cycle time has passed: 34 cycles for both reads and writes with the defaults. A request presented while `req_ready` is low is not accepted and leaves the RAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host presents an access |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_addr | output | ADDR_W | RAM address |
| mem_dq_o | output | DATA_W | Value for the RAM data bus |
| mem_dq_oe | output | 1 | Drive enable for the RAM data bus |
| mem_dq_i | input | DATA_W | Value read from the RAM data bus |

## Verification
Some rules can be checked on every cycle, and the assertions cover those: the strobe only falls under select, the address does not move while selected, the drive enable only turns on while the strobe is low, the strobe-low width equals its derived count, the controller stays busy while selected, and the valid pulse lasts one cycle. The other behaviours need a known start point and known stored contents, so only the bench scenarios can show them. These are the exact distances from select to strobe, from strobe to drive, and from accept to ready. They also include whether data is sampled on the last edge of the access window; the bench RAM model returns garbage until then. Finally, they include the correct data returning after writes at the edge addresses, and that a request held during a busy cycle is dropped.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_TAIL,
        ST_WR_SETUP,
        ST_WR_LOW,
        ST_WR_REC
    } phase_e;

    // Nanoseconds to whole clock cycles, rounded up, at least one cycle.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q == '0)
            cnt_d = '0;
        else
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt     = cnt_q;
    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } cap_t;

    cap_t d, q;

    always_comb begin
        d.data  = capture ? din : q.data;
        d.valid = capture;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata  = q.data;
    assign rvalid = q.valid;

    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 4,
    parameter int CLK_NS     = 4,
    parameter int T_RC_NS    = 135,
    parameter int T_AA_NS    = 135,
    parameter int T_AS_NS    = 10,
    parameter int T_CSL_NS   = 25,
    parameter int T_WP_NS    = 50,
    parameter int T_DS_NS    = 35,
    parameter int T_DH_NS    = 5,
    parameter int T_WR_NS    = 5,
    parameter int T_WC_NS    = 135,
    parameter int T_WZ_NS    = 50,
    parameter int T_AW_NS    = 80,
    parameter int T_CW_NS    = 85
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    // Per-limit cycle counts
    localparam int N_AS  = ns_to_cyc(T_AS_NS,  CLK_NS);
    localparam int N_CSL = ns_to_cyc(T_CSL_NS, CLK_NS);
    localparam int N_WP  = ns_to_cyc(T_WP_NS,  CLK_NS);
    localparam int N_DS  = ns_to_cyc(T_DS_NS,  CLK_NS);
    localparam int N_DH  = ns_to_cyc(T_DH_NS,  CLK_NS);
    localparam int N_WR  = ns_to_cyc(T_WR_NS,  CLK_NS);
    localparam int N_WC  = ns_to_cyc(T_WC_NS,  CLK_NS);
    localparam int N_WZ  = ns_to_cyc(T_WZ_NS,  CLK_NS);
    localparam int N_AW  = ns_to_cyc(T_AW_NS,  CLK_NS);
    localparam int N_CW  = ns_to_cyc(T_CW_NS,  CLK_NS);
    localparam int N_AA  = ns_to_cyc(T_AA_NS,  CLK_NS);
    localparam int N_RC  = ns_to_cyc(T_RC_NS,  CLK_NS);

    // Phase lengths, each covering every limit that bounds it
    localparam int W_SETUP = imax(N_AS, N_CSL);
    localparam int W_LOW   = imax(imax(N_WP, N_WZ + N_DS),
                                  imax(N_AW - W_SETUP, N_CW - W_SETUP));
    localparam int W_REC   = imax(imax(N_DH, N_WR), N_WC - W_SETUP - W_LOW);
    localparam int R_TAIL  = imax(0, N_RC - N_AA);
    localparam int CNT_MAX = imax(imax(W_SETUP, W_LOW), imax(imax(W_REC, R_TAIL), N_AA));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(W_SETUP - 1);
    localparam logic [CNT_W-1:0] LD_LOW   = CNT_W'(W_LOW - 1);
    localparam logic [CNT_W-1:0] LD_REC   = CNT_W'(W_REC - 1);
    localparam logic [CNT_W-1:0] LD_ACC   = CNT_W'(N_AA - 1);
    localparam logic [CNT_W-1:0] LD_TAIL  = CNT_W'(imax(R_TAIL, 1) - 1);
    localparam logic [CNT_W-1:0] OE_ON_AT  = CNT_W'(W_LOW - N_WZ);
    localparam logic [CNT_W-1:0] OE_OFF_AT = CNT_W'(W_REC - N_DH);

    typedef struct packed {
        phase_e            state;
        logic              cs_n;
        logic              we_n;
        logic              oe;
        logic              ready;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ctrl_t;

    ctrl_t d, q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_done;
    logic             cap_en;

    sram_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .expired  (tmr_done)
    );

    sram_read_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_en),
        .din     (mem_dq_i),
        .rdata   (rsp_rdata),
        .rvalid  (rsp_valid)
    );

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_en   = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr   = req_addr;
                    d.cs_n   = 1'b0;
                    d.ready  = 1'b0;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        d.wdata = req_wdata;
                        d.state = ST_WR_SETUP;
                        tmr_val = LD_SETUP;
                    end else begin
                        d.state = ST_RD_ACC;
                        tmr_val = LD_ACC;
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_done) begin
                    cap_en = 1'b1;
                    d.cs_n = 1'b1;
                    if (R_TAIL == 0) begin
                        d.state = ST_IDLE;
                        d.ready = 1'b1;
                    end else begin
                        d.state  = ST_RD_TAIL;
                        tmr_load = 1'b1;
                        tmr_val  = LD_TAIL;
                    end
                end
            end
            ST_RD_TAIL: begin
                if (tmr_done) begin
                    d.state = ST_IDLE;
                    d.ready = 1'b1;
                end
            end
            ST_WR_SETUP: begin
                if (tmr_done) begin
                    d.we_n   = 1'b0;
                    d.state  = ST_WR_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = LD_LOW;
                end
            end
            ST_WR_LOW: begin
                d.oe = (tmr_cnt <= OE_ON_AT);
                if (tmr_done) begin
                    d.we_n   = 1'b1;
                    d.cs_n   = 1'b1;
                    d.state  = ST_WR_REC;
                    tmr_load = 1'b1;
                    tmr_val  = LD_REC;
                end
            end
            ST_WR_REC: begin
                d.oe = (tmr_cnt > OE_OFF_AT);
                if (tmr_done) begin
                    d.state = ST_IDLE;
                    d.ready = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.cs_n  <= 1'b1;
            q.we_n  <= 1'b1;
            q.oe    <= 1'b0;
            q.ready <= 1'b1;
            q.addr  <= '0;
            q.wdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = q.ready;
    assign mem_cs_n  = q.cs_n;
    assign mem_we_n  = q.we_n;
    assign mem_addr  = q.addr;
    assign mem_dq_o  = q.wdata;
    assign mem_dq_oe = q.oe;

    // Checker counter: cycles the write strobe has been seen low
    logic [CNT_W:0] chk_we_low_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        chk_we_low_q <= '0;
        else if (mem_we_n) chk_we_low_q <= '0;
        else               chk_we_low_q <= chk_we_low_q + 1'b1;
    end

    assert_we_under_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    assert_addr_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    assert_we_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (chk_we_low_q == (CNT_W+1)'(W_LOW)));

    assert_drive_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> !mem_we_n);

    assert_busy_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready);
endmodule

// File: tb/test_sram_cycle_ctrl.sv
module test_sram_cycle_ctrl;
    localparam int AW = 10;
    localparam int DW = 4;
    localparam int CLK = 4;

    function automatic int cyc_of(input int ns);
        int c;
        c = (ns + CLK - 1) / CLK;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected counts (R2)
    localparam int E_SETUP = mx(cyc_of(10), cyc_of(25));
    localparam int E_LOW   = mx(mx(cyc_of(50), cyc_of(50) + cyc_of(35)),
                                mx(cyc_of(80) - E_SETUP, cyc_of(85) - E_SETUP));
    localparam int E_DH    = cyc_of(5);
    localparam int E_WZ    = cyc_of(50);
    localparam int E_REC   = mx(mx(E_DH, cyc_of(5)), cyc_of(135) - E_SETUP - E_LOW);
    localparam int E_AA    = cyc_of(135);
    localparam int E_RCYC  = mx(E_AA, cyc_of(135));
    localparam int E_WCYC  = E_SETUP + E_LOW + E_REC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_o;
    logic [DW-1:0] mem_dq_i = '0;
    logic [AW-1:0] mem_addr;

    always #(CLK/2) clk = ~clk;

    sram_cycle_ctrl i_sram_cycle_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // RAM model: data appears only once the access window has run
    logic [DW-1:0] ram [1024];
    logic [DW-1:0] shadow [1024];
    int ram_age = 0;
    initial for (int i = 0; i < 1024; i++) begin ram[i] = '0; shadow[i] = '0; end
    always @(negedge clk) begin
        if (mem_cs_n) ram_age = 0; else ram_age = ram_age + 1;
        if (!mem_cs_n && !mem_we_n && mem_dq_oe) ram[mem_addr] = mem_dq_o;
        if (!mem_cs_n && mem_we_n && ram_age >= E_AA) mem_dq_i <= ram[mem_addr];
        else mem_dq_i <= ~ram[mem_addr];
    end

    // Scoreboard
    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] last_wdata = '0;
    logic [AW-1:0] last_addr = '0;
    bit last_write = 0;

    // Monitor: strobe timing and read results
    logic p_cs = 1, p_we = 1, p_oe = 0, p_rdy = 1;
    int t_cs = 0, t_wef = 0, t_wer = 0;
    always @(negedge clk) if (rst_n) begin
        if (p_cs && !mem_cs_n) t_cs = cyc;
        if (p_rdy && !req_ready) begin
            check("R8 select falls with ready", int'(mem_cs_n), 0);
            check("R4 address presented", int'(mem_addr), int'(last_addr));
        end
        if (p_we && !mem_we_n) begin
            check("R4 select-to-strobe cycles", cyc - t_cs, E_SETUP);
            t_wef = cyc;
        end
        if (!p_oe && mem_dq_oe) begin
            check("R6 strobe-to-drive cycles", cyc - t_wef, E_WZ);
            check("R6 driven data", int'(mem_dq_o), int'(last_wdata));
        end
        if (!p_we && mem_we_n) begin
            check("R5 strobe width", cyc - t_wef, E_LOW);
            check("R7 select rises with strobe", int'(mem_cs_n), 1);
            t_wer = cyc;
        end
        if (p_oe && !mem_dq_oe) check("R6 drive hold cycles", cyc - t_wer, E_DH);
        if (!p_rdy && req_ready)
            check("R8 busy length", cyc - t_cs, last_write ? E_WCYC : E_RCYC);
        if (rsp_valid) begin
            check("R3 access window", cyc - t_cs, E_AA);
            if (exp_q.size() == 0) check("R3 unexpected valid", 1, 0);
            else check("R3 read data", int'(rsp_rdata), int'(exp_q.pop_front()));
        end
        p_cs = mem_cs_n; p_we = mem_we_n; p_oe = mem_dq_oe; p_rdy = req_ready;
    end

    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] dat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = dat;
        last_write = wr; last_addr = a;
        if (wr) begin last_wdata = dat; shadow[a] = dat; end
        else exp_q.push_back(shadow[a]);
        @(negedge clk);
        req_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 cs_n in reset", int'(mem_cs_n), 1);
        check("R1 we_n in reset", int'(mem_we_n), 1);
        check("R1 oe in reset", int'(mem_dq_oe), 0);
        check("R1 ready in reset", int'(req_ready), 1);
        rst_n = 1;
        @(negedge clk);
        check("R1 idle after reset", int'(mem_cs_n) + int'(mem_we_n) + int'(req_ready), 3);

        access(0, 10'h000, 4'h0);           // unwritten word (R3)
        access(1, 10'h000, 4'h5);
        access(1, 10'h3FF, 4'hA);
        access(1, 10'h155, 4'hF);
        access(0, 10'h3FF, 4'h0);
        access(0, 10'h000, 4'h0);
        access(0, 10'h155, 4'h0);
        access(1, 10'h2AA, 4'h3);
        access(1, 10'h2AA, 4'hC);            // overwrite
        access(0, 10'h2AA, 4'h0);

        // R8: request held while busy must be dropped
        access(1, 10'h001, 4'h9);
        req_valid = 1; req_write = 1; req_addr = 10'h155; req_wdata = 4'h6;
        repeat (6) @(negedge clk);
        check("R8 busy while request held", int'(req_ready), 0);
        req_valid = 0;
        access(0, 10'h155, 4'h0);            // expects 4'hF still
        access(0, 10'h001, 4'h0);

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R3 all reads returned", exp_q.size(), 0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule